// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block receives one stereo serial audio lane as a slave. It takes three inputs from the far end: a bit clock, a frame clock that marks left and right, and a data line. It returns left and right samples as 24-bit signed values. A one-cycle strobe marks each finished stereo pair. All three serial inputs are oversampled by the block's own clock. They pass through a synchronizer, and the chosen edge of the bit clock becomes a one-cycle sampling strobe. Everything after that point runs on the block clock.

Four configuration inputs, normally driven from a control register, choose the framing:
- the frame format: right-justified, left-justified, I2S, or DSP with a single start pulse;
- the word length on the wire: 16, 20, 24 or 32 bits;
- the frame-clock polarity, which in DSP format picks the early or late variant instead;
- the bit-clock edge used for sampling.

Each word is aligned into the 24-bit output, whatever its length. The block loads new configuration only when a frame boundary is detected. A change made in the middle of a word therefore never damages that word.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first pair completes, `left_sample` and `right_sample` read zero and `pair_valid` stays low.
- R2: With `cfg_fmt` = 10 (I2S) and `cfg_lrpol` = 0, the left word is carried while the frame clock is low. Its MSB is sampled on the second sampling edge after a frame-clock transition, and the word runs MSB first.
- R3: With `cfg_fmt` = 01 (left-justified) and `cfg_lrpol` = 0, the left word is carried while the frame clock is high. Its MSB is sampled on the first sampling edge after the transition.
- R4: With `cfg_fmt` = 00 (right-justified), the word is the last N bits sampled before a frame-clock transition, where N is the word length. The left word comes from the high phase when `cfg_lrpol` = 0. Word length 11 (32 bits) in this format is handled as 24 bits.
- R5: In formats 00, 01 and 10, setting `cfg_lrpol` to 1 swaps which frame-clock level carries the left channel.
- R6: With `cfg_fmt` = 11 (DSP), a rising frame clock starts a frame, and the left word is followed at once by the right word. With `cfg_lrpol` = 0 (early), the MSB is sampled one edge after the edge that sees the rise. With `cfg_lrpol` = 1 (late), it is sampled on that same edge.
- R7: `cfg_wlen` selects the word length: 00 = 16 bits, 01 = 20 bits, 10 = 24 bits, 11 = 32 bits. A 16-bit or 20-bit word fills the top of the 24-bit output, and the low bits below it are zero. A 24-bit word is passed through unchanged. For a 32-bit word, the low 8 received bits are dropped.
- R8: With `cfg_bcpol` = 0, data and frame clock are sampled on the rising edge of the bit clock. With `cfg_bcpol` = 1, they are sampled on the falling edge.
- R9: In I2S format with 24-bit words, each frame-clock phase may be as short as 24 bit clocks. A shorter word sent MSB first and followed by zeros comes out left-aligned.
- R10: `pair_valid` is high for exactly one clock cycle per completed stereo pair. It rises after the right word is captured, and at that moment both sample outputs update together.
- R11: The configuration inputs take effect only at a frame boundary: any frame-clock transition in formats 00/01/10, or the rising pulse in DSP format. A change held between two boundaries does not alter the word being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock from the far end |
| lrclk | input | 1 | Frame clock (level in formats 00/01/10, start pulse in DSP) |
| sdata | input | 1 | Serial data, MSB first |
| cfg_fmt | input | 2 | Frame format: 00 RJ, 01 LJ, 10 I2S, 11 DSP |
| cfg_wlen | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| cfg_lrpol | input | 1 | Frame-clock polarity, or DSP early (0) / late (1) |
| cfg_bcpol | input | 1 | Bit-clock sampling edge: 0 rising, 1 falling |
| left_sample | output | 24 | Left sample, signed two's complement |
| right_sample | output | 24 | Right sample, signed two's complement |
| pair_valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
Some properties are checked by assertions on every clock:
- the strobe lasts one cycle;
- a pair is only published right after a right-word capture;
- the bit counter restarts after each detected boundary;
- the latched configuration holds still between boundaries;
- every captured 16-bit or 20-bit word carries zero padding.

The bench scenarios show what no single-cycle property can: that each format and variant places the MSB on the correct edge and assigns the correct channel, which only appears as recovered sample values. The same applies to the right-justified tail capture, to the wrapped LSB in short I2S phases, and to a configuration change in mid-word being ignored.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int RAW_BITS = 32;
  localparam int OUT_BITS = 24;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    WL_16 = 2'b00,
    WL_20 = 2'b01,
    WL_24 = 2'b10,
    WL_32 = 2'b11
  } wlen_e;

  typedef struct packed {
    fmt_e  fmt;
    wlen_e wl;
    logic  lrp;
    logic  bcp;
  } rx_cfg_t;

  localparam rx_cfg_t CFG_RESET = '{fmt: FMT_I2S, wl: WL_24, lrp: 1'b0, bcp: 1'b0};

  // Number of bits taken from the wire; 32 is not allowed in right-justified framing.
  function automatic logic [5:0] word_bits(fmt_e f, wlen_e w);
    case (w)
      WL_16:   return 6'd16;
      WL_20:   return 6'd20;
      WL_24:   return 6'd24;
      default: return (f == FMT_RJ) ? 6'd24 : 6'd32;
    endcase
  endfunction

  // Push the last n received bits to the top, then keep the upper 24.
  function automatic logic [OUT_BITS-1:0] to_out(logic [RAW_BITS-1:0] raw, logic [5:0] n);
    logic [RAW_BITS-1:0] al;
    al = raw << (RAW_BITS - int'(n));
    return al[RAW_BITS-1 -: OUT_BITS];
  endfunction

endpackage

// File: rtl/aud_rx_sampler.sv
module aud_rx_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdata,
  input  logic edge_pol,
  output logic samp,
  output logic lr_s,
  output logic d_s
);
  logic [STAGES-1:0] b_q, l_q, d_q;
  logic b_last;
  logic b_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q    <= '0;
      l_q    <= '0;
      d_q    <= '0;
      b_last <= 1'b0;
    end else begin
      b_q    <= {b_q[STAGES-2:0], bclk};
      l_q    <= {l_q[STAGES-2:0], lrclk};
      d_q    <= {d_q[STAGES-2:0], sdata};
      b_last <= b_q[STAGES-1];
    end
  end

  assign b_now = b_q[STAGES-1];
  assign lr_s  = l_q[STAGES-1];
  assign d_s   = d_q[STAGES-1];
  assign samp  = edge_pol ? (b_last & ~b_now) : (~b_last & b_now);

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp,
  input  logic       lr_s,
  input  rx_cfg_t    cfg_in,
  output rx_cfg_t    act,
  output logic [5:0] nbits,
  output logic       boundary,
  output logic       cap_en,
  output logic       cap_right,
  output logic       cap_old
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};

  logic             lr_prev;
  logic [CNT_W-1:0] cnt_q, idx;
  logic [CNT_W-1:0] n_c, off_c;
  logic             is_dsp, left_lvl;

  assign is_dsp   = (act.fmt == FMT_DSP);
  assign nbits    = word_bits(act.fmt, act.wl);
  assign n_c      = CNT_W'(nbits);
  assign off_c    = ((act.fmt == FMT_I2S) || (is_dsp && !act.lrp)) ? ONE : '0;
  assign left_lvl = (act.fmt == FMT_I2S) ? act.lrp : ~act.lrp;
  assign boundary = samp && (is_dsp ? (lr_s & ~lr_prev) : (lr_s ^ lr_prev));
  assign idx      = boundary ? '0 : ((cnt_q == TOP) ? cnt_q : cnt_q + ONE);

  always_comb begin
    cap_en    = 1'b0;
    cap_right = 1'b0;
    cap_old   = 1'b0;
    if (samp) begin
      case (act.fmt)
        FMT_RJ: begin
          if (boundary) begin
            cap_en    = 1'b1;
            cap_old   = 1'b1;
            cap_right = (lr_prev != left_lvl);
          end
        end
        FMT_LJ: begin
          if (!boundary && idx == n_c - ONE) begin
            cap_en    = 1'b1;
            cap_right = (lr_s != left_lvl);
          end
        end
        FMT_I2S: begin
          if (boundary && cnt_q == n_c - ONE) begin
            cap_en    = 1'b1;
            cap_right = (lr_prev != left_lvl);
          end else if (!boundary && idx == n_c) begin
            cap_en    = 1'b1;
            cap_right = (lr_s != left_lvl);
          end
        end
        default: begin
          if (idx == off_c + n_c - ONE) begin
            cap_en = 1'b1;
          end else if (idx == off_c + n_c + n_c - ONE) begin
            cap_en    = 1'b1;
            cap_right = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev <= 1'b0;
      cnt_q   <= '0;
      act     <= CFG_RESET;
    end else if (samp) begin
      lr_prev <= lr_s;
      cnt_q   <= idx;
      if (boundary) act <= cfg_in;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act));  // R11
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt_q == '0));  // R2

endmodule

// File: rtl/aud_rx_shifter.sv
module aud_rx_shifter
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp,
  input  logic                d_s,
  input  logic                use_old,
  input  logic [5:0]          nbits,
  output logic [OUT_BITS-1:0] word
);
  logic [RAW_BITS-1:0] sh_q, sh_nxt;

  assign sh_nxt = {sh_q[RAW_BITS-2:0], d_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (samp) sh_q <= sh_nxt;
  end

  assign word = to_out(use_old ? sh_q : sh_nxt, nbits);

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        sdata,
  input  logic [1:0]  cfg_fmt,
  input  logic [1:0]  cfg_wlen,
  input  logic        cfg_lrpol,
  input  logic        cfg_bcpol,
  output logic [23:0] left_sample,
  output logic [23:0] right_sample,
  output logic        pair_valid
);
  rx_cfg_t             cfg_in, act;
  logic                samp, lr_s, d_s;
  logic [5:0]          nbits;
  logic                boundary, cap_en, cap_right, cap_old;
  logic [OUT_BITS-1:0] word, left_hold;

  assign cfg_in = '{fmt: fmt_e'(cfg_fmt), wl: wlen_e'(cfg_wlen), lrp: cfg_lrpol, bcp: cfg_bcpol};

  aud_rx_sampler #(.STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .edge_pol(act.bcp), .samp(samp), .lr_s(lr_s), .d_s(d_s)
  );

  aud_rx_framer #(.CNT_W(CNT_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .samp(samp), .lr_s(lr_s), .cfg_in(cfg_in),
    .act(act), .nbits(nbits), .boundary(boundary), .cap_en(cap_en),
    .cap_right(cap_right), .cap_old(cap_old)
  );

  aud_rx_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .samp(samp), .d_s(d_s),
    .use_old(cap_old), .nbits(nbits), .word(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold    <= '0;
      left_sample  <= '0;
      right_sample <= '0;
      pair_valid   <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (cap_en) begin
        if (!cap_right) begin
          left_hold <= word;
        end else begin
          left_sample  <= left_hold;
          right_sample <= word;
          pair_valid   <= 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);  // R10
  AST_PAIR_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(cap_en && cap_right));  // R10
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> ((nbits != 6'd16 || word[7:0] == 8'h00) &&
                (nbits != 6'd20 || word[3:0] == 4'h0)));  // R7

endmodule

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0] cfg_fmt = 2'b10, cfg_wlen = 2'b10;
  logic cfg_lrpol = 1'b0, cfg_bcpol = 1'b0;
  logic [23:0] left_sample, right_sample;
  logic pair_valid;

  int n_checks = 0;
  int n_err = 0;
  int got_n = 0;
  logic [23:0] last_l = '0, last_r = '0;

  logic fr_lr [0:127];
  logic fr_d  [0:127];
  int   flen;

  always #4 clk = ~clk;  // 125 MHz

  aud_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_lrpol(cfg_lrpol), .cfg_bcpol(cfg_bcpol),
    .left_sample(left_sample), .right_sample(right_sample), .pair_valid(pair_valid)
  );

  always @(negedge clk) begin
    if (pair_valid) begin
      got_n  = got_n + 1;
      last_l = left_sample;
      last_r = right_sample;
    end
  end

  localparam logic [1:0]  T_FMT [0:11] = '{2'd2, 2'd1, 2'd0, 2'd2, 2'd1, 2'd0, 2'd3, 2'd3, 2'd3, 2'd2, 2'd2, 2'd2};
  localparam logic [1:0]  T_WL  [0:11] = '{2'd2, 2'd0, 2'd1, 2'd3, 2'd2, 2'd3, 2'd2, 2'd0, 2'd3, 2'd2, 2'd2, 2'd2};
  localparam logic        T_LRP [0:11] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        T_BCP [0:11] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam int          T_PH  [0:11] = '{32, 32, 32, 32, 32, 32, 32, 32, 32, 32, 24, 26};
  localparam logic [31:0] T_L   [0:11] = '{32'h00A5C3E1, 32'h00008001, 32'h000F0F0F, 32'hDEADBEEF,
                                           32'h00800001, 32'h00123456, 32'h0055AA55, 32'h0000C001,
                                           32'h87654321, 32'h00135791, 32'h00765432, 32'h00CDEF00};
  localparam logic [31:0] T_R   [0:11] = '{32'h005A3C1E, 32'h00007FFE, 32'h00081234, 32'h12345678,
                                           32'h007FFFFE, 32'h00FEDCBA, 32'h00AA55AA, 32'h00003FFF,
                                           32'h0FEDCBA9, 32'h00246802, 32'h0089ABCD, 32'h00123400};
  localparam string       T_TAG [0:11] = '{"R2", "R3", "R4", "R7", "R8", "R4", "R6", "R6", "R7", "R5", "R9", "R9"};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] actual, input logic [31:0] expected);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
    end
  endtask

  function automatic int bits_for(logic [1:0] f, logic [1:0] w);
    if (w == 2'd0) return 16;
    if (w == 2'd1) return 20;
    if (w == 2'd2 || f == 2'd0) return 24;
    return 32;
  endfunction

  function automatic logic [23:0] expect24(logic [31:0] raw, int n);
    case (n)
      16:      return {raw[15:0], 8'h00};
      20:      return {raw[19:0], 4'h0};
      24:      return raw[23:0];
      default: return raw[31:8];
    endcase
  endfunction

  task automatic build(input logic [1:0] f, input int n, input logic lrp, input int ph,
                       input logic [31:0] wl_left, input logic [31:0] wl_right);
    int s0;
    for (int i = 0; i < 128; i++) begin
      fr_lr[i] = 1'b0;
      fr_d[i]  = 1'b0;
    end
    if (f == 2'd3) begin
      flen = 2 * ph + 2;
      s0 = lrp ? 0 : 1;
      fr_lr[0] = 1'b1;
      for (int k = 0; k < n; k++) begin
        fr_d[s0 + k]     = wl_left[n-1-k];
        fr_d[s0 + n + k] = wl_right[n-1-k];
      end
    end else begin
      logic lvl;
      flen = 2 * ph;
      lvl  = (f == 2'd2) ? lrp : ~lrp;
      for (int i = 0; i < flen; i++) fr_lr[i] = (i < ph) ? lvl : ~lvl;
      s0 = (f == 2'd1) ? 0 : (f == 2'd2) ? 1 : ph - n;
      for (int k = 0; k < n; k++) begin
        fr_d[(s0 + k) % flen]      = wl_left[n-1-k];
        fr_d[(ph + s0 + k) % flen] = wl_right[n-1-k];
      end
    end
  endtask

  task automatic tick(input logic lr, input logic d);
    @(negedge clk);
    bclk  = cfg_bcpol;
    lrclk = lr;
    sdata = d;
    repeat (4) @(negedge clk);
    bclk = ~cfg_bcpol;
    repeat (3) @(negedge clk);
  endtask

  task automatic play(input int frames, input bit glitch);
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < flen; s++) begin
        if (glitch && s == 5)  cfg_wlen = 2'd0;
        if (glitch && s == 30) cfg_wlen = 2'd2;
        tick(fr_lr[s], fr_d[s]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int n;
    logic [23:0] el, er;
    // Reset state (R1)
    repeat (5) @(negedge clk);
    chk(left_sample == 24'h0 && right_sample == 24'h0, "R1", "samples in reset",
        {8'h0, left_sample}, 32'h0);
    chk(pair_valid == 1'b0, "R1", "strobe in reset", {31'h0, pair_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(left_sample == 24'h0 && right_sample == 24'h0 && got_n == 0, "R1", "idle after reset",
        {8'h0, right_sample}, 32'h0);

    // Table of framings
    for (int i = 0; i < 12; i++) begin
      cfg_fmt   = T_FMT[i];
      cfg_wlen  = T_WL[i];
      cfg_lrpol = T_LRP[i];
      cfg_bcpol = T_BCP[i];
      n = bits_for(T_FMT[i], T_WL[i]);
      build(T_FMT[i], n, T_LRP[i], T_PH[i], T_L[i], T_R[i]);
      got_n = 0;
      play(4, 1'b0);
      repeat (8) @(negedge clk);
      el = expect24(T_L[i], n);
      er = expect24(T_R[i], n);
      chk(last_l == el, T_TAG[i], "left sample", {8'h0, last_l}, {8'h0, el});
      chk(last_r == er, T_TAG[i], "right sample", {8'h0, last_r}, {8'h0, er});
      chk(got_n >= 2, "R10", "pairs per scenario", got_n, 2);
    end

    // Mid-word configuration change must wait for the boundary (R11)
    cfg_fmt = 2'd1; cfg_wlen = 2'd2; cfg_lrpol = 1'b0; cfg_bcpol = 1'b0;
    build(2'd1, 24, 1'b0, 32, 32'h00111111, 32'h00222222);
    play(3, 1'b0);
    build(2'd1, 24, 1'b0, 32, 32'h00C3A5E7, 32'h004B2D1F);
    got_n = 0;
    play(1, 1'b1);
    repeat (8) @(negedge clk);
    chk(last_l == 24'hC3A5E7, "R11", "left after mid-word change", {8'h0, last_l}, 32'h00C3A5E7);
    chk(last_r == 24'h4B2D1F, "R11", "right after mid-word change", {8'h0, last_r}, 32'h004B2D1F);
    chk(got_n == 1, "R10", "one pair per frame", got_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule